// File: doc/BRIEF.md
# Output Compare and PWM Channel

This block is one compare channel of a general-purpose timer. It watches the value of the timer's shared counter and compares it with the channel's own compare value. From that comparison it produces a reference waveform and a one-clock event pulse. A 3-bit mode field chooses the reference behaviour at run time:

- hold the level unchanged;
- set the level high on a match, clear it low on a match, or toggle it on a match;
- force the level low or high;
- run one of two PWM shapes that are inverses of each other.

The timer places four of these channels next to its counter.

The compare value is double-buffered. Software writes go into a preload register. The value actually used for comparison is copied from that register only at the counter's update event, so a duty-cycle change takes effect at a period boundary and never in the middle of one.

The channel can be set up as an output or as an input. That setting can only change while the channel enable is low. While the channel is set up as an input, the reference stays low and no event pulses are produced.

Top module: `oc_channel`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `ref_out`, `match_pulse` and `is_input` are 0. The preload and active compare values reset to 0.
- R2: Mode 3'b000 (hold): a match on a tick leaves `ref_out` unchanged.
- R3: Mode 3'b001: a match makes `ref_out` 1 in the cycle after the tick. A match is a cycle with `cnt_tick`=1 and `cnt_val` equal to the active compare value.
- R4: Mode 3'b010: a match makes `ref_out` 0 in the cycle after the tick.
- R5: Mode 3'b011: each match inverts `ref_out` in the cycle after the tick. Without a match, `ref_out` is held.
- R6: Mode 3'b100 drives `ref_out` to 0 and mode 3'b101 drives it to 1, one cycle later, whatever the counter and tick are. In these two modes `match_pulse` stays 0.
- R7: Mode 3'b110 (PWM A): one cycle later, `ref_out` is 1 if the counter is below the active compare value while counting up (`cnt_down`=0). While counting down (`cnt_down`=1), it is 1 if the counter is at or below the compare value. Otherwise it is 0. This mode does not need a tick.
- R8: Mode 3'b111 (PWM B): `ref_out` is the inverse of what PWM A would give for the same inputs.
- R9: `match_pulse` is 1 for exactly the one cycle after each match, in modes 000, 001, 010, 011, 110 and 111. A counter equal to the compare value without a tick gives no pulse.
- R10: A `cmp_wr` writes only the preload register. A cycle with `upd_evt`=1 copies the preload register into the active compare value. If a write and an update fall in the same cycle, the active value takes the older preload contents.
- R11: A `cfg_wr` sets `is_input` to `cfg_input` (1 = input, 0 = output) only when `ch_en`=0. When `ch_en`=1 the write is ignored.
- R12: While `is_input`=1, `ref_out` is 0 in the next cycle and `match_pulse` stays 0, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | CNT_W | Shared counter value |
| cnt_down | input | 1 | Counting direction, 1 = down |
| cnt_tick | input | 1 | Counter advances this cycle |
| upd_evt | input | 1 | Counter update event, loads the active compare value |
| cmp_wr | input | 1 | Write strobe for the compare preload |
| cmp_wdata | input | CNT_W | Compare value to write |
| mode | input | 3 | Reference behaviour select |
| ch_en | input | 1 | Channel enable, locks the direction setting |
| cfg_wr | input | 1 | Write strobe for the direction setting |
| cfg_input | input | 1 | Direction to write, 1 = input |
| ref_out | output | 1 | Registered reference waveform |
| match_pulse | output | 1 | One-cycle compare event |
| is_input | output | 1 | Current direction setting |

## Verification
The assertions assume that every input is known from the first clock after reset and is sampled only at the rising edge. They also assume that `cnt_tick` and `upd_evt` are single-cycle qualifiers, so that a match or a reload is tied to exactly one edge. The stimulus changes inputs only on the falling edge and holds them for a whole cycle. It keeps counter and compare values small and well apart, so that below, equal and above are each hit on purpose. The direction setting is written with `ch_en` both high and low, to show the lock through `is_input`.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [2:0] {
    OC_HOLD  = 3'b000,
    OC_SET   = 3'b001,
    OC_CLR   = 3'b010,
    OC_TGL   = 3'b011,
    OC_FLO   = 3'b100,
    OC_FHI   = 3'b101,
    OC_PWM_A = 3'b110,
    OC_PWM_B = 3'b111
  } oc_mode_e;
endpackage

// File: rtl/oc_preload.sv
module oc_preload #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [CW-1:0] wdata,
  input  logic          upd,
  output logic [CW-1:0] act
);
  logic [CW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      act   <= '0;
    end else begin
      if (wr)  pre_q <= wdata;
      if (upd) act   <= pre_q;
    end
  end

  // R10
  act_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(act));
  // R10
  act_load_chk: assert property (@(posedge clk) disable iff (rst)
    upd |=> act == $past(pre_q));
endmodule

// File: rtl/oc_match.sv
module oc_match
  import oc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] cmp,
  input  logic          down,
  input  logic          tick,
  input  oc_mode_e      mode,
  input  logic          in_mode,
  output logic          hit,
  output logic          below,
  output logic          pulse
);
  logic forced;

  always_comb begin
    hit    = tick && (cnt == cmp) && !in_mode;
    below  = down ? (cnt <= cmp) : (cnt < cmp);
    forced = (mode == OC_FLO) || (mode == OC_FHI);
  end

  always_ff @(posedge clk) begin
    if (rst) pulse <= 1'b0;
    else     pulse <= hit && !forced;
  end

  // R9
  pulse_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
    pulse |-> $past(tick));
  // R6
  force_no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == OC_FLO || mode == OC_FHI) |=> !pulse);
  // R12
  input_no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    in_mode |=> !pulse);
endmodule

// File: rtl/oc_refgen.sv
module oc_refgen
  import oc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  oc_mode_e mode,
  input  logic     hit,
  input  logic     below,
  input  logic     in_mode,
  output logic     ref_q
);
  always_ff @(posedge clk) begin
    if (rst || in_mode) begin
      ref_q <= 1'b0;
    end else begin
      unique case (mode)
        OC_HOLD:  ref_q <= ref_q;
        OC_SET:   if (hit) ref_q <= 1'b1;
        OC_CLR:   if (hit) ref_q <= 1'b0;
        OC_TGL:   if (hit) ref_q <= ~ref_q;
        OC_FLO:   ref_q <= 1'b0;
        OC_FHI:   ref_q <= 1'b1;
        OC_PWM_A: ref_q <= below;
        OC_PWM_B: ref_q <= ~below;
        default:  ref_q <= ref_q;
      endcase
    end
  end

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == OC_HOLD && !in_mode) |=> $stable(ref_q));
  // R5
  toggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == OC_TGL && hit) |=> ref_q != $past(ref_q));
  // R6
  force_high_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == OC_FHI && !in_mode) |=> ref_q);
  // R12
  input_low_chk: assert property (@(posedge clk) disable iff (rst)
    in_mode |=> !ref_q);
endmodule

// File: rtl/oc_channel.sv
module oc_channel
  import oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_down,
  input  logic             cnt_tick,
  input  logic             upd_evt,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic [2:0]       mode,
  input  logic             ch_en,
  input  logic             cfg_wr,
  input  logic             cfg_input,
  output logic             ref_out,
  output logic             match_pulse,
  output logic             is_input
);
  localparam int CW = CNT_W;

  oc_mode_e      mode_e;
  logic [CW-1:0] cmp_act;
  logic          hit, below;

  assign mode_e = oc_mode_e'(mode);

  always_ff @(posedge clk) begin
    if (rst)                  is_input <= 1'b0;
    else if (cfg_wr && !ch_en) is_input <= cfg_input;
  end

  oc_preload #(.CW(CW)) u_pre (
    .clk(clk), .rst(rst), .wr(cmp_wr), .wdata(cmp_wdata),
    .upd(upd_evt), .act(cmp_act)
  );

  oc_match #(.CW(CW)) u_match (
    .clk(clk), .rst(rst), .cnt(cnt_val), .cmp(cmp_act), .down(cnt_down),
    .tick(cnt_tick), .mode(mode_e), .in_mode(is_input),
    .hit(hit), .below(below), .pulse(match_pulse)
  );

  oc_refgen u_ref (
    .clk(clk), .rst(rst), .mode(mode_e), .hit(hit), .below(below),
    .in_mode(is_input), .ref_q(ref_out)
  );

  // R11
  cfg_lock_chk: assert property (@(posedge clk) disable iff (rst)
    ch_en |=> $stable(is_input));
endmodule

// File: tb/oc_channel_tb.sv
`timescale 1ns/1ps
module oc_channel_tb;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] cnt_val = '0, cmp_wdata = '0;
  logic cnt_down = 0, cnt_tick = 0, upd_evt = 0, cmp_wr = 0;
  logic [2:0] mode = '0;
  logic ch_en = 0, cfg_wr = 0, cfg_input = 0;
  logic ref_out, match_pulse, is_input;

  always #2 clk = ~clk;

  oc_channel #(.CNT_W(W)) u_dut (
    .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_down(cnt_down),
    .cnt_tick(cnt_tick), .upd_evt(upd_evt), .cmp_wr(cmp_wr),
    .cmp_wdata(cmp_wdata), .mode(mode), .ch_en(ch_en), .cfg_wr(cfg_wr),
    .cfg_input(cfg_input), .ref_out(ref_out), .match_pulse(match_pulse),
    .is_input(is_input)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [2:0] exp_q[$];
  string      tag_q[$];

  // reference model state, built from the requirements
  logic [W-1:0] m_pre = '0, m_act = '0;
  logic m_ref = 0, m_in = 0;

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {ref,pulse,is_input} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input logic [W-1:0] c, input logic dn, input logic tk,
                      input logic up, input logic wr, input logic [W-1:0] wd,
                      input logic [2:0] md, input logic en, input logic cw,
                      input logic cd, input string tag);
    logic hit, blw, pls, nref;
    @(negedge clk);
    cnt_val = c; cnt_down = dn; cnt_tick = tk; upd_evt = up;
    cmp_wr = wr; cmp_wdata = wd; mode = md; ch_en = en;
    cfg_wr = cw; cfg_input = cd;
    hit  = tk && (c == m_act) && !m_in;
    pls  = hit && !(md == 3'b100 || md == 3'b101);
    blw  = dn ? (c <= m_act) : (c < m_act);
    nref = m_ref;
    if (m_in) nref = 1'b0;
    else case (md)
      3'b001: if (hit) nref = 1'b1;
      3'b010: if (hit) nref = 1'b0;
      3'b011: if (hit) nref = ~m_ref;
      3'b100: nref = 1'b0;
      3'b101: nref = 1'b1;
      3'b110: nref = blw;
      3'b111: nref = ~blw;
      default: nref = m_ref;
    endcase
    m_ref = nref;
    if (up) m_act = m_pre;
    if (wr) m_pre = wd;
    if (cw && !en) m_in = cd;
    exp_q.push_back({nref, pls, m_in});
    tag_q.push_back(tag);
  endtask

  // monitor: compare each expected item one sample after the edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [2:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {ref_out, match_pulse, is_input}, e);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1", {ref_out, match_pulse, is_input}, 3'b000);
    @(negedge clk) rst = 0;
    @(posedge clk);
    #1 check("R1", {ref_out, match_pulse, is_input}, 3'b000);
    // double buffer load
    step(0,  0,0,0, 1,10, 3'd0, 0,0,0, "R10");
    step(0,  0,0,1, 0,0,  3'd0, 0,0,0, "R10");
    step(0,  0,0,0, 1,20, 3'd1, 0,0,0, "R10");
    step(20, 0,1,0, 0,0,  3'd1, 0,0,0, "R10");
    // match-driven modes
    step(10, 0,1,0, 0,0,  3'd1, 0,0,0, "R3");
    step(10, 0,0,0, 0,0,  3'd1, 0,0,0, "R9");
    step(11, 0,1,0, 0,0,  3'd2, 0,0,0, "R9");
    step(10, 0,1,0, 0,0,  3'd2, 0,0,0, "R4");
    step(10, 0,1,0, 0,0,  3'd1, 0,0,0, "R3");
    step(10, 0,1,0, 0,0,  3'd0, 0,0,0, "R2");
    step(5,  0,1,0, 0,0,  3'd0, 0,0,0, "R2");
    step(10, 0,1,0, 0,0,  3'd3, 0,0,0, "R5");
    step(10, 0,1,0, 0,0,  3'd3, 0,0,0, "R5");
    step(9,  0,1,0, 0,0,  3'd3, 0,0,0, "R5");
    step(10, 0,0,0, 0,0,  3'd3, 0,0,0, "R5");
    // forced levels
    step(10, 0,1,0, 0,0,  3'd5, 0,0,0, "R6");
    step(3,  0,0,0, 0,0,  3'd4, 0,0,0, "R6");
    step(10, 0,1,0, 0,0,  3'd4, 0,0,0, "R6");
    // PWM shapes with compare 20
    step(0,  0,0,1, 0,0,  3'd4, 0,0,0, "R10");
    step(5,  0,0,0, 0,0,  3'd6, 0,0,0, "R7");
    step(20, 0,0,0, 0,0,  3'd6, 0,0,0, "R7");
    step(25, 0,0,0, 0,0,  3'd6, 0,0,0, "R7");
    step(20, 1,0,0, 0,0,  3'd6, 0,0,0, "R7");
    step(21, 1,0,0, 0,0,  3'd6, 0,0,0, "R7");
    step(5,  0,0,0, 0,0,  3'd7, 0,0,0, "R8");
    step(20, 0,1,0, 0,0,  3'd7, 0,0,0, "R8");
    step(20, 1,0,0, 0,0,  3'd7, 0,0,0, "R8");
    // write and update in the same cycle
    step(0,  0,0,0, 1,40, 3'd6, 0,0,0, "R10");
    step(0,  0,0,1, 1,50, 3'd6, 0,0,0, "R10");
    step(45, 0,0,0, 0,0,  3'd6, 0,0,0, "R10");
    step(0,  0,0,1, 0,0,  3'd6, 0,0,0, "R10");
    step(45, 0,0,0, 0,0,  3'd6, 0,0,0, "R10");
    // direction setting and input behaviour
    step(0,  0,0,0, 0,0,  3'd6, 1,1,1, "R11");
    step(50, 0,1,0, 0,0,  3'd5, 0,1,1, "R11");
    step(50, 0,1,0, 0,0,  3'd1, 0,0,0, "R12");
    step(1,  0,0,0, 0,0,  3'd5, 0,0,0, "R12");
    step(50, 0,1,0, 0,0,  3'd3, 1,1,0, "R11");
    step(0,  0,0,0, 0,0,  3'd6, 0,1,0, "R11");
    step(10, 0,0,0, 0,0,  3'd6, 0,0,0, "R12");
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule